// File: doc/BRIEF.md
# Serially Configured One-of-Four Output Router

This block takes one data bit and hands it to exactly one of four output lanes. The lane is picked by a small configuration word. That word is not written over a bus. It is shifted in one bit per clock through a scan-style chain, so a whole row of tiles can be programmed from a single serial line. The bit that leaves the end of the chain comes out on a serial output, which feeds the next tile in the row.

While the scan enable is low, the configuration word stays put and the data path is purely combinational: the selected lane follows the data input in the same cycle. Each lane has a data bit and an output-enable bit. A lane that is not selected has its enable low and its data held at 0. That pair stands in for a released, high-impedance output, so a pad ring or a bus keeper built around the block decides what a released lane means. No handshake is involved. The data input is a level that is steered, not a stream of transfers, so it has no valid/ready pair and there is no back-pressure to define.

Top module: `scan_route_demux`

## Requirements
- R1: While the active-low reset `rst_n` is low, the configuration word is 0, whatever the clock is doing. In that state lane 0 is enabled (`route_oe` = 4'b0001) and `scan_out` is 0.
- R2: On a rising clock edge where `clk_en` and `scan_en` are both high, the configuration word shifts one place toward its most significant bit and takes `scan_in` as its new least significant bit. After two such shifts, the first bit shifted in is bit 1 of the word and the second is bit 0.
- R3: For a configuration value k (0 to 3), `route_data[k]` equals `din` in the same cycle, with no clock edge needed.
- R4: Exactly one bit of `route_oe` is high, and it is bit k for configuration value k.
- R5: Every lane that is not selected has its `route_oe` bit low and its `route_data` bit 0, for either value of `din`.
- R6: While `scan_en` is low, the configuration word and `scan_out` hold, whatever `scan_in` does.
- R7: While `clk_en` is low, no shift happens even with `scan_en` high.
- R8: `scan_out` presents bit 1 of the configuration word, which is the bit the next shift pushes out of the chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable for the configuration chain |
| scan_en | input | 1 | High selects the shift operation |
| scan_in | input | 1 | Serial configuration input |
| scan_out | output | 1 | Serial output toward the next tile |
| din | input | 1 | Data bit to be routed |
| route_data | output | 4 | Per-lane data; 0 on lanes that are not selected |
| route_oe | output | 4 | Per-lane output enable; one-hot |

## Verification
A configuration change, and the matching change on `scan_out`, is due on the first rising edge where the shift is enabled. The routing outputs are due in the same cycle as a change on `din`, because no register lies between them. Reset clears the route as soon as it is asserted, without waiting for an edge. The bench therefore changes its inputs on the falling edge. It samples 1 ns later: after one rising edge for chain effects, and after no edge at all for data and reset effects. That way every sample falls either after the register has updated or while the path is combinationally settled.

// File: rtl/scan_demux_pkg.sv
package scan_demux_pkg;
  // Operation the configuration chain performs on the next rising edge.
  typedef enum logic {
    CHAIN_HOLD  = 1'b0,
    CHAIN_SHIFT = 1'b1
  } chain_op_e;

  // Chain operation for a given pair of enables.
  function automatic chain_op_e chain_op(input logic ce, input logic se);
    return (ce && se) ? CHAIN_SHIFT : CHAIN_HOLD;
  endfunction
endpackage

// File: rtl/sdm_cfg_chain.sv
module sdm_cfg_chain
  import scan_demux_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             scan_en,
  input  logic             scan_in,
  output logic [SEL_W-1:0] cfg_q,
  output logic             scan_out
);
  chain_op_e op;

  always_comb op = chain_op(clk_en, scan_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (op == CHAIN_SHIFT) begin
      cfg_q <= SEL_W'({cfg_q, scan_in});
    end
  end

  // The most significant bit is the one the next shift pushes out.
  assign scan_out = cfg_q[SEL_W-1];
endmodule

// File: rtl/sdm_decode.sv
module sdm_decode #(
  parameter int NUM_OUT = 4,
  parameter int SEL_W   = 2
) (
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_OUT-1:0] oe
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane_dec
    assign oe[i] = (sel == SEL_W'(i));
  end
endmodule

// File: rtl/sdm_lane_drive.sv
module sdm_lane_drive #(
  parameter int NUM_OUT = 4
) (
  input  logic               din,
  input  logic [NUM_OUT-1:0] oe,
  output logic [NUM_OUT-1:0] data
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane_drv
    assign data[i] = oe[i] & din;
  end
endmodule

// File: rtl/scan_route_demux.sv
module scan_route_demux #(
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_en,
  input  logic               scan_en,
  input  logic               scan_in,
  output logic               scan_out,
  input  logic               din,
  output logic [NUM_OUT-1:0] route_data,
  output logic [NUM_OUT-1:0] route_oe
);
  localparam int SEL_W = (NUM_OUT > 2) ? $clog2(NUM_OUT) : 1;

  logic [SEL_W-1:0] cfg_q;

  sdm_cfg_chain #(.SEL_W(SEL_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .scan_en  (scan_en),
    .scan_in  (scan_in),
    .cfg_q    (cfg_q),
    .scan_out (scan_out)
  );

  sdm_decode #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_dec (
    .sel (cfg_q),
    .oe  (route_oe)
  );

  sdm_lane_drive #(.NUM_OUT(NUM_OUT)) u_drv (
    .din  (din),
    .oe   (route_oe),
    .data (route_data)
  );
endmodule

// File: rtl/scan_route_demux_chk.sv
module scan_route_demux_chk #(
  parameter int NUM_OUT = 4,
  parameter int SEL_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clk_en,
  input logic               scan_en,
  input logic               scan_in,
  input logic               scan_out,
  input logic               din,
  input logic [NUM_OUT-1:0] route_data,
  input logic [NUM_OUT-1:0] route_oe,
  input logic [SEL_W-1:0]   cfg_q
);
  // R1: one edge into reset, lane 0 is enabled and the serial output is low
  p_reset_lane0_r1: assert property (@(posedge clk)
    !rst_n |=> (route_oe == NUM_OUT'(1) && !scan_out));

  // R2: an enabled shift moves the word up and inserts scan_in
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && scan_en) |=> cfg_q == SEL_W'({$past(cfg_q), $past(scan_in)}));

  // R3: the enabled lane carries din
  p_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (route_data & route_oe) == (din ? route_oe : '0));

  // R4: exactly one lane is enabled
  p_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(route_oe) == 1);

  // R5: released lanes carry 0
  p_released_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (route_data & ~route_oe) == '0);

  // R6: with scan disabled, the route and the serial output hold
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> ($stable(route_oe) && $stable(scan_out)));

  // R7: with the clock enable low, the route holds
  p_ce_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(route_oe));
endmodule

bind scan_route_demux scan_route_demux_chk #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_en     (clk_en),
  .scan_en    (scan_en),
  .scan_in    (scan_in),
  .scan_out   (scan_out),
  .din        (din),
  .route_data (route_data),
  .route_oe   (route_oe),
  .cfg_q      (cfg_q)
);

// File: tb/tb_scan_route_demux.sv
module tb_scan_route_demux;
  localparam int CLK_PERIOD = 10;
  localparam int NOUT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b0;
  logic scan_en = 1'b0;
  logic scan_in = 1'b0;
  logic din = 1'b0;
  logic scan_out;
  logic [NOUT-1:0] route_data;
  logic [NOUT-1:0] route_oe;

  int n_checks = 0;
  int n_fail = 0;
  logic [1:0] exp_cfg = 2'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_route_demux #(.NUM_OUT(NOUT)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .scan_en(scan_en),
    .scan_in(scan_in), .scan_out(scan_out), .din(din),
    .route_data(route_data), .route_oe(route_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Checks every lane, and the serial output, against the expected word.
  task automatic check_lanes(input string req);
    logic [NOUT-1:0] sel = NOUT'(1) << exp_cfg;
    check({req, " oe"}, 8'(route_oe), 8'(sel));
    check({req, " data"}, 8'(route_data), din ? 8'(sel) : 8'h00);
    check({req, " scan_out"}, 8'(scan_out), 8'(exp_cfg[1]));
  endtask

  // R2, R8: one enabled shift
  task automatic shift_bit(input logic b);
    @(negedge clk);
    scan_en = 1'b1; clk_en = 1'b1; scan_in = b;
    @(posedge clk);
    exp_cfg = {exp_cfg[0], b};
    @(negedge clk);
    scan_en = 1'b0; clk_en = 1'b0;
    #1 check_lanes("R2/R8 shift");
  endtask

  task automatic load_cfg(input logic [1:0] k);
    shift_bit(k[1]);
    shift_bit(k[0]);
  endtask

  // R1: reset state, including a change on din while in reset
  task automatic t_reset_state();
    #1;
    exp_cfg = 2'd0;
    din = 1'b0; #1 check_lanes("R1 reset din0");
    din = 1'b1; #1 check_lanes("R1 reset din1");
    din = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R3, R4, R5: each route, with both values of din
  task automatic t_route_all();
    for (int k = 0; k < NOUT; k++) begin
      load_cfg(2'(k));
      din = 1'b1; #1;
      check("R3 routed lane", 8'(route_data[k]), 8'h01);
      check("R4 onehot", 8'(route_oe), 8'(NOUT'(1) << k));
      check("R5 released zero din1", 8'(route_data & ~route_oe), 8'h00);
      din = 1'b0; #1;
      check("R3 routed lane din0", 8'(route_data[k]), 8'h00);
      check("R5 released zero din0", 8'(route_data), 8'h00);
    end
  endtask

  // R8: bits leave the chain in the order they were shifted in
  task automatic t_scan_chain();
    load_cfg(2'b01);
    shift_bit(1'b0);
    check("R8 bit leaving", 8'(scan_out), 8'h01);
    shift_bit(1'b1);
    check("R8 bit leaving 2", 8'(scan_out), 8'h00);
  endtask

  // R6: scan_en low, so scan_in toggles are ignored
  task automatic t_hold_scan_low();
    load_cfg(2'b10);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      clk_en = 1'b1; scan_en = 1'b0; scan_in = ~scan_in;
      @(negedge clk);
      #1 check_lanes("R6 hold");
    end
    clk_en = 1'b0;
  endtask

  // R7: clk_en low, so no shift happens
  task automatic t_hold_ce_low();
    load_cfg(2'b01);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      clk_en = 1'b0; scan_en = 1'b1; scan_in = 1'b1;
      @(negedge clk);
      #1 check_lanes("R7 ce low");
    end
    scan_en = 1'b0;
  endtask

  // R1: reset asserted between edges clears the route at once
  task automatic t_async_reset();
    load_cfg(2'b11);
    din = 1'b1;
    @(negedge clk);
    #2 rst_n = 1'b0;
    exp_cfg = 2'd0;
    #1 check_lanes("R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    din = 1'b0;
    #1 check_lanes("R1 after release");
  endtask

  initial begin
    t_reset_state();
    t_route_all();
    t_scan_chain();
    t_hold_scan_low();
    t_hold_ce_low();
    t_async_reset();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule